// File: doc/BRIEF.md
# Store Queue with Deferred Writeback

This block is the per-thread store buffer of an out-of-order core. Stores enter in program order at the tail when dispatched, and each receives a slot index. Later, an execute step fills that slot with the store's byte size and data. When the commit stage retires stores, it sends one sequence number, and every live store older than that number becomes eligible to write to memory. A writeback pointer sits between the oldest entry (head) and the allocation point (tail). It walks forward and hands eligible stores to a data-memory write port one at a time.

A slot is released only after memory reports that its write is done. Committing a store does not free it. On a misprediction, a squash carrying a sequence number drops every store younger than that number by pulling the tail back. If a squash and an allocation arrive in the same cycle, the squash wins and the allocation is dropped. If the memory port refuses a write, the queue holds that store and sends nothing until a retry strobe arrives. It then offers the same store again. One slot always stays empty, so head equal to tail means only "empty".

Top module: `store_queue`

## Requirements
- R1: After reset, occupancy, wb_pending and alloc_idx are 0, and full and mem_wr_valid are low.
- R2: full is high exactly when occupancy is at least SLOTS-1. An allocation request while full is ignored: alloc_idx and occupancy do not change.
- R3: An accepted allocation takes the slot shown on alloc_idx, and alloc_idx advances by one modulo SLOTS in the next cycle. The new slot starts with size, data and all flags cleared, so it is never written or freed before it is committed.
- R4: An execute strobe stores exec_size and exec_data into slot exec_idx. Those values appear on mem_wr_size and mem_wr_data when that store is written back, with its sequence number on mem_wr_seq.
- R5: A commit marks every live, not yet committed store whose sequence number is strictly below commit_seq. wb_pending rises by the number marked, and a store that was never committed is never offered to memory.
- R6: Writes are offered in queue order, oldest first. After a write is accepted (mem_wr_valid and mem_wr_ready both high), no further write is offered until mem_done has been seen.
- R7: A write offered while mem_wr_ready is low is refused. mem_wr_valid then stays low until mem_retry pulses, after which the same store is offered again.
- R8: A store leaves the queue only after its write is done. Occupancy is unchanged by commit and by acceptance, and drops by one in the second cycle after mem_done.
- R9: A squash removes every live store whose sequence number is greater than squash_seq. The tail moves back, so occupancy becomes the number of survivors and alloc_idx points just past the youngest survivor.
- R10: wb_pending falls by one for each accepted write and returns to 0 once every committed store has been sent.
- R11: The writeback pointer never lies outside the span from head to tail, and the tail is always exactly occupancy slots ahead of the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the allocated store |
| alloc_idx | output | IDX_W | Slot the next allocation will take (tail) |
| full | output | 1 | Queue holds SLOTS-1 stores |
| exec_valid | input | 1 | Execute step delivers size and data |
| exec_idx | input | IDX_W | Slot being filled |
| exec_size | input | SIZE_W | Store size in bytes |
| exec_data | input | DATA_W | Store data |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Stores older than this become eligible |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| mem_wr_valid | output | 1 | A write is offered to memory |
| mem_wr_ready | input | 1 | Memory accepts the offered write |
| mem_wr_size | output | SIZE_W | Size of the offered write |
| mem_wr_data | output | DATA_W | Data of the offered write |
| mem_wr_seq | output | SEQ_W | Sequence number of the offered write |
| mem_retry | input | 1 | Memory can take the refused write again |
| mem_done | input | 1 | The accepted write has finished |
| occupancy | output | CNT_W | Number of stores held |
| wb_pending | output | CNT_W | Committed stores not yet accepted by memory |

## Verification
A writeback pointer that falls behind the head, or slips past the tail, shows up on the memory port as the wrong sequence number at the very next offer. It can also show up as an offer of a store that was never committed. Either way the scoreboard catches it within a few cycles of the commit. Flags that are not cleared on reuse show up differently: a recycled slot is either freed at once or sent early, so occupancy or mem_wr_valid goes wrong within two cycles of the allocation. A wrong tail after a squash is visible on alloc_idx in the cycle after the squash. A lost count is visible on occupancy and full once the queue drains.

// File: rtl/sq_pkg.sv
package sq_pkg;

  typedef struct packed {
    logic can_wb;
    logic committed;
    logic completed;
  } sq_flags_t;

  typedef enum logic [1:0] {
    WB_READY    = 2'd0,
    WB_HELD     = 2'd1,
    WB_INFLIGHT = 2'd2
  } wb_state_t;

  // Step an index forward around the ring.
  function automatic int unsigned ring_add(input int unsigned idx, input int unsigned step,
                                           input int unsigned slots);
    return (idx + step) % slots;
  endfunction

  // Number of forward steps from one index to another around the ring.
  function automatic int unsigned ring_dist(input int unsigned from_idx, input int unsigned to_idx,
                                            input int unsigned slots);
    return (to_idx + slots - from_idx) % slots;
  endfunction

endpackage

// File: rtl/sq_slot_array.sv
module sq_slot_array
  import sq_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SEQ_W  = 16,
  parameter int SIZE_W = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(SLOTS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_en,
  input  logic [IDX_W-1:0]             alloc_idx,
  input  logic [SEQ_W-1:0]             alloc_seq,
  input  logic                         exec_en,
  input  logic [IDX_W-1:0]             exec_idx,
  input  logic [SIZE_W-1:0]            exec_size,
  input  logic [DATA_W-1:0]            exec_data,
  input  logic [SLOTS-1:0]             commit_mask,
  input  logic                         done_en,
  input  logic [IDX_W-1:0]             done_idx,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [SEQ_W-1:0]             rd_seq,
  output logic [SIZE_W-1:0]            rd_size,
  output logic [DATA_W-1:0]            rd_data,
  output logic [SLOTS-1:0][SEQ_W-1:0]  seq_vec,
  output logic [SLOTS-1:0]             canwb_vec,
  output logic [SLOTS-1:0]             committed_vec,
  output logic [SLOTS-1:0]             completed_vec
);

  logic [SLOTS-1:0][SIZE_W-1:0] size_vec;
  logic [SLOTS-1:0][DATA_W-1:0] data_vec;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [SEQ_W-1:0]  seq_r;
    logic [SIZE_W-1:0] size_r;
    logic [DATA_W-1:0] data_r;
    sq_flags_t         flags_r;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seq_r   <= '0;
        size_r  <= '0;
        data_r  <= '0;
        flags_r <= '0;
      end else if (alloc_en && alloc_idx == IDX_W'(g)) begin
        seq_r   <= alloc_seq;
        size_r  <= '0;
        data_r  <= '0;
        flags_r <= '0;
      end else begin
        if (exec_en && exec_idx == IDX_W'(g)) begin
          size_r <= exec_size;
          data_r <= exec_data;
        end
        if (commit_mask[g]) begin
          flags_r.can_wb    <= 1'b1;
          flags_r.committed <= 1'b1;
        end
        if (done_en && done_idx == IDX_W'(g)) begin
          flags_r.completed <= 1'b1;
        end
      end
    end

    assign seq_vec[g]       = seq_r;
    assign size_vec[g]      = size_r;
    assign data_vec[g]      = data_r;
    assign canwb_vec[g]     = flags_r.can_wb;
    assign committed_vec[g] = flags_r.committed;
    assign completed_vec[g] = flags_r.completed;
  end

  assign rd_seq  = seq_vec[rd_idx];
  assign rd_size = size_vec[rd_idx];
  assign rd_data = data_vec[rd_idx];

endmodule

// File: rtl/sq_age_decode.sv
module sq_age_decode
  import sq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int SEQ_W = 16,
  parameter int IDX_W = $clog2(SLOTS),
  parameter int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic [IDX_W-1:0]            head,
  input  logic [CNT_W-1:0]            count,
  input  logic [SLOTS-1:0][SEQ_W-1:0] seq_vec,
  input  logic [SLOTS-1:0]            committed_vec,
  input  logic                        commit_en,
  input  logic [SEQ_W-1:0]            commit_seq,
  input  logic [SEQ_W-1:0]            squash_seq,
  output logic [SLOTS-1:0]            commit_mask,
  output logic [CNT_W-1:0]            commit_num,
  output logic [CNT_W-1:0]            survivors
);

  logic [SLOTS-1:0] live;
  logic [SLOTS-1:0] keep;

  for (genvar g = 0; g < SLOTS; g++) begin : g_age
    assign live[g] = ring_dist(32'(head), g, SLOTS) < 32'(count);
    assign commit_mask[g] = commit_en && live[g] && !committed_vec[g] &&
                            (seq_vec[g] < commit_seq);
    assign keep[g] = live[g] && (seq_vec[g] <= squash_seq);
  end

  always_comb begin
    commit_num = '0;
    survivors  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      commit_num = commit_num + CNT_W'(commit_mask[i]);
      survivors  = survivors + CNT_W'(keep[i]);
    end
  end

endmodule

// File: rtl/sq_wb_engine.sv
module sq_wb_engine
  import sq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int IDX_W = $clog2(SLOTS),
  parameter int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] tail,
  input  logic             entry_can_wb,
  input  logic             entry_completed,
  input  logic [CNT_W-1:0] commit_num,
  input  logic             mem_ready,
  input  logic             mem_retry,
  input  logic             mem_done,
  output logic [IDX_W-1:0] wb_idx,
  output logic             issue,
  output logic             done_en,
  output logic [IDX_W-1:0] done_idx,
  output logic [CNT_W-1:0] pending,
  output wb_state_t        state
);

  logic             accept;
  logic [IDX_W-1:0] inflight_idx;

  assign issue    = (state == WB_READY) && (wb_idx != tail) && entry_can_wb && !entry_completed;
  assign accept   = issue && mem_ready;
  assign done_en  = (state == WB_INFLIGHT) && mem_done;
  assign done_idx = inflight_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= WB_READY;
      wb_idx       <= '0;
      inflight_idx <= '0;
      pending      <= '0;
    end else begin
      pending <= pending + commit_num - CNT_W'(accept);
      unique case (state)
        WB_READY: begin
          if (accept) begin
            state        <= WB_INFLIGHT;
            inflight_idx <= wb_idx;
            wb_idx       <= IDX_W'(ring_add(32'(wb_idx), 1, SLOTS));
          end else if (issue) begin
            state <= WB_HELD;
          end
        end
        WB_HELD:     if (mem_retry) state <= WB_READY;
        WB_INFLIGHT: if (mem_done)  state <= WB_READY;
        default:     state <= WB_READY;
      endcase
    end
  end

endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int SEQ_W  = 16,
  parameter int SIZE_W = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(SLOTS),
  parameter int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic [IDX_W-1:0]  alloc_idx,
  output logic              full,
  input  logic              exec_valid,
  input  logic [IDX_W-1:0]  exec_idx,
  input  logic [SIZE_W-1:0] exec_size,
  input  logic [DATA_W-1:0] exec_data,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [SIZE_W-1:0] mem_wr_size,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic [SEQ_W-1:0]  mem_wr_seq,
  input  logic              mem_retry,
  input  logic              mem_done,
  output logic [CNT_W-1:0]  occupancy,
  output logic [CNT_W-1:0]  wb_pending
);

  logic [IDX_W-1:0] head_q, tail_q, wb_idx;
  logic [CNT_W-1:0] count_q;

  // Named internal events, brought out for the checker.
  logic alloc_en, free_en, done_en;
  logic [IDX_W-1:0] done_idx;
  wb_state_t wb_state;

  logic [SLOTS-1:0][SEQ_W-1:0] seq_vec;
  logic [SLOTS-1:0] canwb_vec, committed_vec, completed_vec, commit_mask;
  logic [CNT_W-1:0] commit_num, survivors;

  assign full     = count_q >= CNT_W'(SLOTS - 1);
  assign alloc_en = alloc_valid && !full && !squash_valid;
  assign free_en  = (count_q != '0) && completed_vec[head_q];

  sq_slot_array #(
    .SLOTS(SLOTS), .SEQ_W(SEQ_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_slots (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_en), .alloc_idx(tail_q), .alloc_seq(alloc_seq),
    .exec_en(exec_valid), .exec_idx(exec_idx), .exec_size(exec_size), .exec_data(exec_data),
    .commit_mask(commit_mask),
    .done_en(done_en), .done_idx(done_idx),
    .rd_idx(wb_idx), .rd_seq(mem_wr_seq), .rd_size(mem_wr_size), .rd_data(mem_wr_data),
    .seq_vec(seq_vec), .canwb_vec(canwb_vec), .committed_vec(committed_vec),
    .completed_vec(completed_vec)
  );

  sq_age_decode #(
    .SLOTS(SLOTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_age (
    .head(head_q), .count(count_q), .seq_vec(seq_vec), .committed_vec(committed_vec),
    .commit_en(commit_valid), .commit_seq(commit_seq), .squash_seq(squash_seq),
    .commit_mask(commit_mask), .commit_num(commit_num), .survivors(survivors)
  );

  sq_wb_engine #(
    .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_wb (
    .clk(clk), .rst_n(rst_n), .tail(tail_q),
    .entry_can_wb(canwb_vec[wb_idx]), .entry_completed(completed_vec[wb_idx]),
    .commit_num(commit_num), .mem_ready(mem_wr_ready), .mem_retry(mem_retry),
    .mem_done(mem_done), .wb_idx(wb_idx), .issue(mem_wr_valid),
    .done_en(done_en), .done_idx(done_idx), .pending(wb_pending), .state(wb_state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (free_en) head_q <= IDX_W'(ring_add(32'(head_q), 1, SLOTS));
      if (squash_valid) begin
        tail_q  <= IDX_W'(ring_add(32'(head_q), 32'(survivors), SLOTS));
        count_q <= survivors - CNT_W'(free_en);
      end else begin
        if (alloc_en) tail_q <= IDX_W'(ring_add(32'(tail_q), 1, SLOTS));
        count_q <= count_q + CNT_W'(alloc_en) - CNT_W'(free_en);
      end
    end
  end

  assign alloc_idx = tail_q;
  assign occupancy = count_q;

endmodule

// File: rtl/sq_checker.sv
module sq_checker
  import sq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int SEQ_W = 16,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] head,
  input logic [IDX_W-1:0] tail,
  input logic [IDX_W-1:0] wb_idx,
  input logic [CNT_W-1:0] count,
  input logic             full,
  input logic             alloc_valid,
  input logic             squash_valid,
  input logic [IDX_W-1:0] alloc_idx,
  input logic             mem_wr_valid,
  input logic             mem_wr_ready,
  input logic [SEQ_W-1:0] mem_wr_seq,
  input logic [CNT_W-1:0] wb_pending
);

  logic             refused_q;
  logic [SEQ_W-1:0] refused_seq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refused_q     <= 1'b0;
      refused_seq_q <= '0;
    end else if (mem_wr_valid && !mem_wr_ready) begin
      refused_q     <= 1'b1;
      refused_seq_q <= mem_wr_seq;
    end else if (mem_wr_valid) begin
      refused_q <= 1'b0;
    end
  end

  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= 32'(SLOTS - 1)); // R2
  AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    full && alloc_valid && !squash_valid |=> alloc_idx == $past(alloc_idx)); // R2
  AST_PENDING_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> wb_pending != '0); // R5
  AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && mem_wr_ready |=> !mem_wr_valid); // R6
  AST_QUIET_AFTER_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> !mem_wr_valid); // R7
  AST_RESEND_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    refused_q && mem_wr_valid |-> mem_wr_seq == refused_seq_q); // R7
  AST_TAIL_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    ring_dist(32'(head), 32'(tail), SLOTS) == 32'(count)); // R11
  AST_WB_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    ring_dist(32'(head), 32'(wb_idx), SLOTS) <= 32'(count)); // R11

endmodule

bind store_queue sq_checker #(
  .SLOTS(SLOTS), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_sq_checker (
  .clk(clk), .rst_n(rst_n), .head(head_q), .tail(tail_q), .wb_idx(wb_idx),
  .count(count_q), .full(full), .alloc_valid(alloc_valid), .squash_valid(squash_valid),
  .alloc_idx(alloc_idx), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_seq(mem_wr_seq), .wb_pending(wb_pending)
);

// File: tb/store_queue_bench.sv
module store_queue_bench;
  localparam int SLOTS = 8, SEQ_W = 16, SIZE_W = 4, DATA_W = 32;
  localparam int IDX_W = $clog2(SLOTS), CNT_W = $clog2(SLOTS + 1);
  localparam int ITEM_W = SEQ_W + SIZE_W + DATA_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, exec_valid = 0, commit_valid = 0, squash_valid = 0;
  logic [SEQ_W-1:0] alloc_seq = '0, commit_seq = '0, squash_seq = '0;
  logic [IDX_W-1:0] exec_idx = '0;
  logic [SIZE_W-1:0] exec_size = '0;
  logic [DATA_W-1:0] exec_data = '0;
  logic mem_wr_ready = 0, mem_retry = 0, mem_done = 0;
  logic [IDX_W-1:0] alloc_idx;
  logic full, mem_wr_valid;
  logic [SIZE_W-1:0] mem_wr_size;
  logic [DATA_W-1:0] mem_wr_data;
  logic [SEQ_W-1:0] mem_wr_seq;
  logic [CNT_W-1:0] occupancy, wb_pending;

  always #4 clk = ~clk;

  store_queue #(.SLOTS(SLOTS), .SEQ_W(SEQ_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_store_queue (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .alloc_idx(alloc_idx), .full(full), .exec_valid(exec_valid), .exec_idx(exec_idx),
    .exec_size(exec_size), .exec_data(exec_data), .commit_valid(commit_valid),
    .commit_seq(commit_seq), .squash_valid(squash_valid), .squash_seq(squash_seq),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_size(mem_wr_size),
    .mem_wr_data(mem_wr_data), .mem_wr_seq(mem_wr_seq), .mem_retry(mem_retry),
    .mem_done(mem_done), .occupancy(occupancy), .wb_pending(wb_pending)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [ITEM_W-1:0] exp_q[$];
  int uncommitted[$];
  int b_tail = 0;
  int refuse_cnt = 0;
  bit out_b = 0, blocked_b = 0;
  int done_wait = 0, retry_wait = 0;

  function automatic logic [SIZE_W-1:0] size_of(int s);
    return SIZE_W'((s % 4) + 1);
  endfunction
  function automatic logic [DATA_W-1:0] data_of(int s);
    return (DATA_W'(s) * 32'h0101_0101) ^ 32'hA5A5_0000;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put_store(int s);
    logic [IDX_W-1:0] slot;
    slot = alloc_idx;
    alloc_valid = 1; alloc_seq = SEQ_W'(s);
    @(negedge clk);
    alloc_valid = 0;
    b_tail = (b_tail + 1) % SLOTS;
    chk("R3 alloc_idx advance", int'(alloc_idx), b_tail);
    exec_valid = 1; exec_idx = slot; exec_size = size_of(s); exec_data = data_of(s);
    @(negedge clk);
    exec_valid = 0;
    uncommitted.push_back(s);
  endtask

  task automatic commit_below(int c);
    while (uncommitted.size() > 0 && uncommitted[0] < c) begin
      int s = uncommitted.pop_front();
      exp_q.push_back({SEQ_W'(s), size_of(s), data_of(s)});
    end
    commit_valid = 1; commit_seq = SEQ_W'(c);
    @(negedge clk);
    commit_valid = 0;
  endtask

  task automatic squash_above(int s);
    int removed = 0;
    while (uncommitted.size() > 0 && uncommitted[uncommitted.size()-1] > s) begin
      void'(uncommitted.pop_back());
      removed++;
    end
    squash_valid = 1; squash_seq = SEQ_W'(s);
    @(negedge clk);
    squash_valid = 0;
    b_tail = (b_tail + SLOTS - removed) % SLOTS;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || out_b || blocked_b) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Memory model and scoreboard monitor.
  initial begin
    forever begin
      @(negedge clk);
      mem_done = 0; mem_retry = 0; mem_wr_ready = 0;
      if (rst_n) begin
        if (out_b) begin
          chk("R6 no offer while a write is in flight", int'(mem_wr_valid), 0);
          if (done_wait == 0) begin mem_done = 1; out_b = 0; end
          else done_wait--;
        end else if (blocked_b) begin
          chk("R7 silent until retry", int'(mem_wr_valid), 0);
          if (retry_wait == 0) begin mem_retry = 1; blocked_b = 0; end
          else retry_wait--;
        end else if (mem_wr_valid) begin
          if (refuse_cnt > 0) begin
            refuse_cnt--; blocked_b = 1; retry_wait = 2;
          end else begin
            logic [ITEM_W-1:0] got, want;
            got = {mem_wr_seq, mem_wr_size, mem_wr_data};
            checks++;
            if (exp_q.size() == 0) begin
              fails++;
              $display("FAIL R5 unexpected write: actual %h expected none", got);
            end else begin
              want = exp_q.pop_front();
              if (got !== want) begin
                fails++;
                $display("FAIL R4/R6 write content: actual %h expected %h", got, want);
              end
            end
            mem_wr_ready = 1; out_b = 1; done_wait = 2;
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 occupancy", int'(occupancy), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 mem_wr_valid", int'(mem_wr_valid), 0);
    chk("R1 alloc_idx", int'(alloc_idx), 0);
    chk("R1 wb_pending", int'(wb_pending), 0);

    // Five stores, commit the three oldest.
    for (int s = 10; s < 15; s++) put_store(s);
    commit_below(13);
    chk("R5 wb_pending after commit", int'(wb_pending), 3);
    chk("R8 occupancy unchanged by commit", int'(occupancy), 5);
    wait_idle();
    chk("R8 occupancy after completions", int'(occupancy), 2);
    chk("R10 wb_pending drained", int'(wb_pending), 0);
    chk("R5 uncommitted not offered", int'(mem_wr_valid), 0);

    // Squash the three youngest.
    for (int s = 15; s < 18; s++) put_store(s);
    chk("R9 occupancy before squash", int'(occupancy), 5);
    squash_above(14);
    chk("R9 occupancy after squash", int'(occupancy), 2);
    chk("R9 tail pulled back", int'(alloc_idx), b_tail);

    // Fill across the wrap, reach full, try one more.
    for (int s = 20; s < 25; s++) put_store(s);
    chk("R2 full at SLOTS-1", int'(full), 1);
    alloc_valid = 1; alloc_seq = 16'd25;
    @(negedge clk);
    alloc_valid = 0;
    chk("R2 alloc_idx held when full", int'(alloc_idx), b_tail);
    chk("R2 occupancy held when full", int'(occupancy), 7);

    // Commit everything with one refusal on the first offer.
    refuse_cnt = 1;
    commit_below(100);
    chk("R5 wb_pending after full commit", int'(wb_pending), 7);
    wait_idle();
    chk("R8 drained occupancy", int'(occupancy), 0);
    chk("R2 full cleared", int'(full), 0);
    chk("R10 wb_pending zero", int'(wb_pending), 0);
    chk("R7 refusal consumed", refuse_cnt, 0);

    // Reused slot must start clean.
    put_store(30);
    repeat (8) @(negedge clk);
    chk("R3 reused slot not offered", int'(mem_wr_valid), 0);
    chk("R3 reused slot not freed", int'(occupancy), 1);
    commit_below(31);
    wait_idle();
    chk("R8 final occupancy", int'(occupancy), 0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule